// File: doc/BRIEF.md
# Receive Word Acceptance Filter for a Two-Wire Avionics Serial Bus

This block sits between a receive deserializer and a receive FIFO. Every time the deserializer reports a complete 32-bit word, the block decides in one cycle whether to keep it. It can reverse the order of the 8-bit label field, require two source/destination bits to match programmed values, check odd parity, and consult a 256-entry per-label acceptance table. Each of these checks has its own enable bit in a control register. Words that pass are pushed into the FIFO through a one-cycle write strobe.

Three programmable priority labels run alongside the FIFO path. When a word passes the parity and source/destination checks and its label equals one of them, the word is copied into that comparator's single-word mailbox and the mailbox is marked full. A host read of the mailbox clears the mark. One more control bit selects the line rate and is handed on to the deserializer.

Top module: `a429_rx_filter`

## Requirements
- R1: After reset the control register reads 0x00, no mailbox is full, the FIFO write strobe is low and the low-speed output is 0.
- R2: With control bit 0 set, bits 7:0 of the word (the label) are stored bit-reversed, so word bit 0 lands at bit 7 and so on. The reversed label is also used for the table and the priority comparison.
- R3: With control bit 2 set, a word is dropped unless word bit 8 equals control bit 3 and word bit 9 equals control bit 4.
- R4: With control bit 1 set, a word is dropped unless its 32 bits hold an odd number of ones (bit 31 is the parity bit). With bit 1 clear, all 32 bits are stored unchanged.
- R5: With control bit 5 clear, every word that passes the other checks is stored. With it set, a word is stored only if the table entry indexed by its label is 1. Table entries reset to 0 and are written through the table port.
- R6: With control bit 6 set, a word that passes R3 and R4 and whose label equals priority label i is written into mailbox i and sets mbxFull[i], whatever the table and FIFO state. With bit 6 clear, no mailbox is ever written.
- R7: A cycle with mbxRdEn high clears mbxFull[mbxRdSel], and mbxRdData always shows the selected mailbox. A new match while the mailbox is full overwrites it.
- R8: fifoWrEn is high for exactly the one cycle after an accepted word, carrying the stored word. It stays low for a word presented while fifoFull is high.
- R9: Control bit 7 drives rateLow: 0 selects the high rate and 1 selects one eighth of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Control register write strobe |
| cfgWrData | input | 8 | Control register write value |
| cfgRdData | output | 8 | Current control register value |
| tblWrEn | input | 1 | Label table write strobe |
| tblWrAddr | input | 8 | Label table entry index |
| tblWrBit | input | 1 | Value written to the table entry |
| prioWrEn | input | 1 | Priority label write strobe |
| prioWrSel | input | 2 | Priority comparator index (0 to 2) |
| prioWrLabel | input | 8 | Priority label value |
| wordValid | input | 1 | Received word is present this cycle |
| wordIn | input | 32 | Received word, bit 0 is the first bit on the line |
| fifoFull | input | 1 | Receive FIFO cannot take a word |
| fifoWrEn | output | 1 | Receive FIFO write strobe |
| fifoWrData | output | 32 | Word written to the FIFO |
| mbxRdEn | input | 1 | Host read of a mailbox, clears its full flag |
| mbxRdSel | input | 2 | Mailbox selected for reading |
| mbxRdData | output | 32 | Contents of the selected mailbox |
| mbxFull | output | 3 | Per-mailbox full flags |
| rateLow | output | 1 | Rate select for the deserializer |

## Verification
The hardest case to reach is a mailbox overwrite whose outcome depends on the order of events. A priority label must be matched while bit-reversal is on, so the label is compared after the swap. A second matching word must then replace the first before the host reads it, and the FIFO must be full at the same time. The stimulus first programs the comparators with reversal off and confirms that nothing is captured. It then turns priority capture on, holds fifoFull high and sends two words with the same label. It checks that mbxFull is set, that the FIFO strobe stays low and that the mailbox holds the second word. Only then does it pulse the read that clears the flag.

// File: rtl/a429_filt_pkg.sv
package a429_filt_pkg;
  localparam int WORD_W  = 32;
  localparam int LABEL_W = 8;
  localparam int NUM_PRIO = 3;

  typedef struct packed {
    logic lowSpeed;   // bit 7
    logic prioEn;     // bit 6
    logic filterEn;   // bit 5
    logic sd10;       // bit 4
    logic sd9;        // bit 3
    logic sdiEn;      // bit 2
    logic parityEn;   // bit 1
    logic flipEn;     // bit 0
  } ctrlReg_t;

  typedef struct packed {
    logic                fifoPush;
    logic [NUM_PRIO-1:0] mbxLoad;
  } strobes_t;
endpackage

// File: rtl/a429_filt_ctrl.sv
module a429_filt_ctrl
  import a429_filt_pkg::*;
#(
  parameter int LBL_W = LABEL_W,
  parameter int NPRIO = NUM_PRIO,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [7:0]       cfgWrData,
  input  logic             tblWrEn,
  input  logic [LBL_W-1:0] tblWrAddr,
  input  logic             tblWrBit,
  input  logic             prioWrEn,
  input  logic [SEL_W-1:0] prioWrSel,
  input  logic [LBL_W-1:0] prioWrLabel,
  input  logic             wordValid,
  input  logic             fifoFull,
  input  logic [LBL_W-1:0] label,
  input  logic             parityOk,
  input  logic [1:0]       sdBits,
  output ctrlReg_t         ctrl,
  output strobes_t         strobes
);
  localparam int TBL_DEPTH = 1 << LBL_W;

  logic [TBL_DEPTH-1:0] labelTable;
  logic [LBL_W-1:0]     prioLabel [NPRIO];
  logic                 checksPass;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrl <= '0;
    end else if (cfgWrEn) begin
      ctrl <= ctrlReg_t'(cfgWrData);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      labelTable <= '0;
    end else if (tblWrEn) begin
      labelTable[tblWrAddr] <= tblWrBit;
    end
  end

  for (genvar i = 0; i < NPRIO; i++) begin : g_prio
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prioLabel[i] <= '0;
      end else if (prioWrEn && prioWrSel == SEL_W'(i)) begin
        prioLabel[i] <= prioWrLabel;
      end
    end
    assign strobes.mbxLoad[i] = wordValid && checksPass && ctrl.prioEn &&
                                (label == prioLabel[i]);
  end

  always_comb begin
    checksPass = (!ctrl.parityEn || parityOk) &&
                 (!ctrl.sdiEn || sdBits == {ctrl.sd10, ctrl.sd9});
    strobes.fifoPush = wordValid && checksPass && !fifoFull &&
                       (!ctrl.filterEn || labelTable[label]);
  end
endmodule

// File: rtl/a429_filt_dp.sv
module a429_filt_dp
  import a429_filt_pkg::*;
#(
  parameter int WD_W  = WORD_W,
  parameter int LBL_W = LABEL_W,
  parameter int NPRIO = NUM_PRIO,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WD_W-1:0]  wordIn,
  input  logic             flipEn,
  input  strobes_t         strobes,
  input  logic             mbxRdEn,
  input  logic [SEL_W-1:0] mbxRdSel,
  output logic [LBL_W-1:0] label,
  output logic             parityOk,
  output logic [1:0]       sdBits,
  output logic             fifoWrEn,
  output logic [WD_W-1:0]  fifoWrData,
  output logic [WD_W-1:0]  mbxRdData,
  output logic [NPRIO-1:0] mbxFull
);
  logic [LBL_W-1:0] revLabel;
  logic [WD_W-1:0]  wordFix;
  logic [WD_W-1:0]  mbx [NPRIO];

  for (genvar b = 0; b < LBL_W; b++) begin : g_rev
    assign revLabel[b] = wordIn[LBL_W-1-b];
  end

  assign label    = flipEn ? revLabel : wordIn[LBL_W-1:0];
  assign wordFix  = {wordIn[WD_W-1:LBL_W], label};
  assign parityOk = ^wordIn;
  assign sdBits   = wordIn[LBL_W+1:LBL_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoWrEn   <= 1'b0;
      fifoWrData <= '0;
    end else begin
      fifoWrEn <= strobes.fifoPush;
      if (strobes.fifoPush) fifoWrData <= wordFix;
    end
  end

  for (genvar i = 0; i < NPRIO; i++) begin : g_mbx
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mbx[i]     <= '0;
        mbxFull[i] <= 1'b0;
      end else if (strobes.mbxLoad[i]) begin
        mbx[i]     <= wordFix;
        mbxFull[i] <= 1'b1;
      end else if (mbxRdEn && mbxRdSel == SEL_W'(i)) begin
        mbxFull[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    mbxRdData = '0;
    for (int i = 0; i < NPRIO; i++) begin
      if (mbxRdSel == SEL_W'(i)) mbxRdData = mbx[i];
    end
  end
endmodule

// File: rtl/a429_rx_filter.sv
module a429_rx_filter
  import a429_filt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [7:0]  cfgWrData,
  output logic [7:0]  cfgRdData,
  input  logic        tblWrEn,
  input  logic [7:0]  tblWrAddr,
  input  logic        tblWrBit,
  input  logic        prioWrEn,
  input  logic [1:0]  prioWrSel,
  input  logic [7:0]  prioWrLabel,
  input  logic        wordValid,
  input  logic [31:0] wordIn,
  input  logic        fifoFull,
  output logic        fifoWrEn,
  output logic [31:0] fifoWrData,
  input  logic        mbxRdEn,
  input  logic [1:0]  mbxRdSel,
  output logic [31:0] mbxRdData,
  output logic [2:0]  mbxFull,
  output logic        rateLow
);
  ctrlReg_t       ctrl;
  strobes_t       strobes;
  logic [7:0]     label;
  logic           parityOk;
  logic [1:0]     sdBits;

  a429_filt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .tblWrEn(tblWrEn), .tblWrAddr(tblWrAddr), .tblWrBit(tblWrBit),
    .prioWrEn(prioWrEn), .prioWrSel(prioWrSel), .prioWrLabel(prioWrLabel),
    .wordValid(wordValid), .fifoFull(fifoFull),
    .label(label), .parityOk(parityOk), .sdBits(sdBits),
    .ctrl(ctrl), .strobes(strobes)
  );

  a429_filt_dp u_dp (
    .clk(clk), .rstN(rstN),
    .wordIn(wordIn), .flipEn(ctrl.flipEn), .strobes(strobes),
    .mbxRdEn(mbxRdEn), .mbxRdSel(mbxRdSel),
    .label(label), .parityOk(parityOk), .sdBits(sdBits),
    .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData),
    .mbxRdData(mbxRdData), .mbxFull(mbxFull)
  );

  assign cfgRdData = ctrl;
  assign rateLow   = ctrl.lowSpeed;
endmodule

// File: rtl/a429_rx_filter_chk.sv
module a429_rx_filter_chk (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  cfgRdData,
  input logic        wordValid,
  input logic        fifoFull,
  input logic        fifoWrEn,
  input logic [31:0] fifoWrData,
  input logic        mbxRdEn,
  input logic [1:0]  mbxRdSel,
  input logic [2:0]  mbxFull,
  input logic        rateLow
);
  // A FIFO push only follows a presented word while the FIFO had room
  assert_push_needs_room_R8: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> ($past(wordValid) && !$past(fifoFull)));

  // Stored words obey parity when the check was on
  assert_push_odd_parity_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fifoWrEn && $past(cfgRdData[1])) |-> (^fifoWrData));

  // Stored words carry the programmed source/destination bits when checked
  assert_push_sdi_match_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fifoWrEn && $past(cfgRdData[2])) |->
      (fifoWrData[9:8] == $past(cfgRdData[4:3])));

  // No mailbox fills while priority capture was off
  assert_no_mbx_when_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cfgRdData[6]) |-> ((mbxFull & ~$past(mbxFull)) == 3'b000));

  // A full flag drops only after a host read of that mailbox
  assert_clear_by_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    (($past(mbxFull) & ~mbxFull) != 3'b000) |->
      ($past(mbxRdEn) && $onehot0($past(mbxFull) & ~mbxFull)));

  // Rate output follows control bit 7
  assert_rate_bit_R9: assert property (@(posedge clk) disable iff (!rstN)
    rateLow == cfgRdData[7]);
endmodule

bind a429_rx_filter a429_rx_filter_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgRdData(cfgRdData), .wordValid(wordValid),
  .fifoFull(fifoFull), .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData),
  .mbxRdEn(mbxRdEn), .mbxRdSel(mbxRdSel), .mbxFull(mbxFull), .rateLow(rateLow)
);

// File: tb/a429_rx_filter_tb_top.sv
module a429_rx_filter_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgWrData = '0;
  logic [7:0]  cfgRdData;
  logic        tblWrEn = 1'b0;
  logic [7:0]  tblWrAddr = '0;
  logic        tblWrBit = 1'b0;
  logic        prioWrEn = 1'b0;
  logic [1:0]  prioWrSel = '0;
  logic [7:0]  prioWrLabel = '0;
  logic        wordValid = 1'b0;
  logic [31:0] wordIn = '0;
  logic        fifoFull = 1'b0;
  logic        fifoWrEn;
  logic [31:0] fifoWrData;
  logic        mbxRdEn = 1'b0;
  logic [1:0]  mbxRdSel = '0;
  logic [31:0] mbxRdData;
  logic [2:0]  mbxFull;
  logic        rateLow;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  a429_rx_filter dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] oddify(input logic [31:0] w);
    logic [31:0] r = {1'b0, w[30:0]};
    if ($countones(r) % 2 == 0) r[31] = 1'b1;
    return r;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = v[7-b];
    return r;
  endfunction

  task automatic setCfg(input logic [7:0] v);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic setTbl(input logic [7:0] a, input logic v);
    @(negedge clk); tblWrEn = 1'b1; tblWrAddr = a; tblWrBit = v;
    @(negedge clk); tblWrEn = 1'b0;
  endtask

  task automatic setPrio(input logic [1:0] s, input logic [7:0] l);
    @(negedge clk); prioWrEn = 1'b1; prioWrSel = s; prioWrLabel = l;
    @(negedge clk); prioWrEn = 1'b0;
  endtask

  // Presents one word; on return the registered outputs show its result
  task automatic sendWord(input logic [31:0] w);
    @(negedge clk); wordValid = 1'b1; wordIn = w;
    @(negedge clk); wordValid = 1'b0;
  endtask

  task automatic expectPush(input string req, input logic [31:0] w, input logic [31:0] exp);
    sendWord(w);
    check(req, {31'b0, fifoWrEn}, 32'd1);
    check(req, fifoWrData, exp);
  endtask

  task automatic expectDrop(input string req, input logic [31:0] w);
    sendWord(w);
    check(req, {31'b0, fifoWrEn}, 32'd0);
  endtask

  task automatic t_reset;
    check("R1 cfg", {24'b0, cfgRdData}, 32'h0);
    check("R1 mbxFull", {29'b0, mbxFull}, 32'h0);
    check("R1 fifoWrEn", {31'b0, fifoWrEn}, 32'h0);
    check("R1 rateLow", {31'b0, rateLow}, 32'h0);
  endtask

  task automatic t_plain;
    // R4 disabled: an even-parity word is stored unchanged
    expectPush("R4 no check", 32'h0000_0003, 32'h0000_0003);
    @(negedge clk);
    check("R8 single pulse", {31'b0, fifoWrEn}, 32'd0);
    expectPush("R5 filter off", 32'h1234_5678, 32'h1234_5678);
  endtask

  task automatic t_flip;
    setCfg(8'h01);
    expectPush("R2 flip", 32'hABCD_EF01, 32'hABCD_EF80);
    expectPush("R2 flip b", 32'h0000_00C2, {24'h0, rev8(8'hC2)});
    setCfg(8'h00);
  endtask

  task automatic t_parity;
    logic [31:0] w;
    setCfg(8'h02);
    w = oddify(32'h0055_1234);
    expectPush("R4 odd accepted", w, w);
    expectDrop("R4 even rejected", w ^ 32'h8000_0000);
    setCfg(8'h00);
  endtask

  task automatic t_sdi;
    setCfg(8'h0C); // sdiEn, sd9=1, sd10=0
    expectPush("R3 match", 32'h0000_0133, 32'h0000_0133);
    expectDrop("R3 mismatch", 32'h0000_0233);
    expectDrop("R3 both set", 32'h0000_0333);
    setCfg(8'h00);
  endtask

  task automatic t_filter;
    setTbl(8'h55, 1'b1);
    setCfg(8'h20);
    expectPush("R5 listed label", 32'h1111_1155, 32'h1111_1155);
    expectDrop("R5 unlisted label", 32'h1111_1156);
    setCfg(8'h21); // flip too: raw 0xAA reverses to 0x55
    expectPush("R5 table after flip", 32'h0000_00AA, 32'h0000_0055);
    setCfg(8'h00);
  endtask

  task automatic t_prio;
    setPrio(2'd0, 8'h10);
    setPrio(2'd1, 8'h20);
    setPrio(2'd2, 8'h30);
    sendWord(32'h0000_0020);
    check("R6 off no capture", {29'b0, mbxFull}, 32'h0);
    setCfg(8'h41); // prioEn + flip
    fifoFull = 1'b1;
    sendWord({24'hAAAAAA, rev8(8'h20)});
    check("R8 full blocks push", {31'b0, fifoWrEn}, 32'd0);
    check("R6 capture", {29'b0, mbxFull}, 32'h2);
    sendWord({24'h555555, rev8(8'h20)});
    mbxRdSel = 2'd1;
    #1;
    check("R7 overwrite", mbxRdData, 32'h5555_5520);
    fifoFull = 1'b0;
    @(negedge clk); mbxRdEn = 1'b1;
    @(negedge clk); mbxRdEn = 1'b0;
    check("R7 read clears", {29'b0, mbxFull}, 32'h0);
    setCfg(8'h00);
  endtask

  task automatic t_rate;
    setCfg(8'h80);
    check("R9 low rate", {31'b0, rateLow}, 32'd1);
    setCfg(8'h00);
    check("R9 high rate", {31'b0, rateLow}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_flip();
    t_parity();
    t_sdi();
    t_filter();
    t_prio();
    t_rate();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule